// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core between four power modes: full-power, doze, nap and sleep. Software selects a low-power target through a two-bit mode field together with a power-save enable bit. The controller then drives one enable per functional unit and one enable each for the bus snoop logic, the timer/decrementer, the thermal unit, the PLL and the DLL. It also watches the wake sources, the quiesce-acknowledge input and a PLL-lock indication.

Each low-power mode keeps a different set of domains alive and accepts a different set of wake events. Nap drops back to doze while quiesce-acknowledge is low, so that snooping can be serviced. It returns to nap once the acknowledge comes back. Sleep holds any wake event pending until the PLL has reported lock for a programmable number of consecutive cycles. A hard reset request overrides every other transition. A one-cycle pulse marks each return to full-power.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `cur_mode` is 00 (full-power), `wake_done` is low and every domain enable is high.
- R2: In full-power with `psave_en` high, a `mode_sel` of 01 (doze), 10 (nap) or 11 (sleep) becomes `cur_mode` at the next edge. A `mode_sel` of 00 has no effect. The request is also refused in any cycle where a wake source valid for the target mode is active.
- R3: In full-power every domain enable is high, and `unit_en[i]` is low exactly when `dpm_en` and `unit_idle[i]` are both high.
- R4: In doze, only snoop, timer, thermal, PLL and DLL are enabled. Nap additionally clears snoop. Sleep clears every enable, including PLL and DLL.
- R5: In doze or nap, any of `ext_irq`, `smi`, `dec_exc`, `soft_rst` or `mchk` moves the block to full-power at the next edge.
- R6: In nap with no wake source, a low `qack` moves the block to doze at the next edge.
- R7: In a doze that was entered from nap, a high `qack` with no wake source returns the block to nap at the next edge. A doze entered from full-power ignores `qack`.
- R8: In sleep, `dec_exc` is not a wake source. `ext_irq`, `smi`, `soft_rst` and `mchk` are latched as a pending wake.
- R9: The block leaves sleep only at an edge where `pll_locked` is high, a pending or present wake exists, and the count of consecutive earlier edges with `pll_locked` high in sleep is at least `relock_cycles`. A low `pll_locked` restarts that count.
- R10: `hard_rst` forces full-power at the next edge from any mode, with priority over every other transition.
- R11: `wake_done` is high for exactly the first cycle in which `cur_mode` is 00 after a cycle in a low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psave_en | input | 1 | Power-save request enable |
| mode_sel | input | 2 | Requested low-power mode |
| dpm_en | input | 1 | Dynamic idle gating enable in full-power |
| unit_idle | input | NUM_UNITS | Per-unit idle indication |
| ext_irq | input | 1 | External interrupt wake |
| smi | input | 1 | System management interrupt wake |
| dec_exc | input | 1 | Decrementer exception wake |
| soft_rst | input | 1 | Soft reset wake |
| hard_rst | input | 1 | Hard reset request, highest priority |
| mchk | input | 1 | Machine-check wake |
| qack | input | 1 | Quiesce acknowledge |
| pll_locked | input | 1 | PLL lock indication |
| relock_cycles | input | CNT_W | Required consecutive locked edges before leaving sleep |
| unit_en | output | NUM_UNITS | Functional unit enables |
| snoop_en | output | 1 | Bus snoop logic enable |
| timer_en | output | 1 | Timer/decrementer enable |
| thermal_en | output | 1 | Thermal unit enable |
| pll_en | output | 1 | PLL keep-powered request |
| dll_en | output | 1 | DLL keep-powered request |
| cur_mode | output | 2 | Current mode: 00 full, 01 doze, 10 nap, 11 sleep |
| wake_done | output | 1 | One-cycle pulse on return to full-power |

## Verification
Two transitions can fall in one edge. A wake event and a qack change can coincide in nap or in a doze entered from nap. A hard reset can arrive together with a wake, a mode request or a qack fall. A wake can also arrive in the very edge where the relock count is satisfied. Directed cases force each of these pairings, and random stimulus with frequent qack toggles and sparse wakes produces many more. Every edge is judged against a bench model in which wake beats the qack fallback and hard reset beats everything. A wake present in the lock-satisfying edge is taken at that edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PM_FULL  = 2'b00,
      PM_DOZE  = 2'b01,
      PM_NAP   = 2'b10,
      PM_SLEEP = 2'b11
   } pm_mode_e;

   typedef struct packed {
      logic units;
      logic snoop;
      logic timer;
      logic thermal;
      logic pll;
      logic dll;
   } dom_en_t;

   // Domains kept alive in each mode
   function automatic dom_en_t mode_domains(pm_mode_e m);
      dom_en_t d;
      unique case (m)
         PM_FULL:  d = '{units: 1'b1, snoop: 1'b1, timer: 1'b1, thermal: 1'b1, pll: 1'b1, dll: 1'b1};
         PM_DOZE:  d = '{units: 1'b0, snoop: 1'b1, timer: 1'b1, thermal: 1'b1, pll: 1'b1, dll: 1'b1};
         PM_NAP:   d = '{units: 1'b0, snoop: 1'b0, timer: 1'b1, thermal: 1'b1, pll: 1'b1, dll: 1'b1};
         PM_SLEEP: d = '{units: 1'b0, snoop: 1'b0, timer: 1'b0, thermal: 1'b0, pll: 1'b0, dll: 1'b0};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pmc_relock_timer.sv
module pmc_relock_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_sleep,
   input  logic             pll_locked,
   input  logic [CNT_W-1:0] relock_cycles,
   output logic             lock_ok
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] lock_cnt;

   // Counts consecutive locked edges while in sleep, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_cnt <= '0;
      end else if (!in_sleep || !pll_locked) begin
         lock_cnt <= '0;
      end else if (lock_cnt != CNT_MAX) begin
         lock_cnt <= lock_cnt + 1'b1;
      end
   end

   assign lock_ok = pll_locked && (lock_cnt >= relock_cycles);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       psave_en,
   input  logic [1:0] mode_sel,
   input  logic       ext_irq,
   input  logic       smi,
   input  logic       dec_exc,
   input  logic       soft_rst,
   input  logic       hard_rst,
   input  logic       mchk,
   input  logic       qack,
   input  logic       lock_ok,
   output pm_mode_e   mode,
   output logic       wake_done
);

   pm_mode_e state, nxt, req;
   logic     from_nap, nxt_from_nap;
   logic     pend, nxt_pend;
   logic     wake_lp, wake_sl, req_blocked;

   assign wake_sl     = ext_irq | smi | soft_rst | mchk;
   assign wake_lp     = wake_sl | dec_exc;
   assign req         = pm_mode_e'(mode_sel);
   assign req_blocked = (req == PM_SLEEP) ? wake_sl : wake_lp;

   always_comb begin
      nxt          = state;
      nxt_from_nap = from_nap;
      nxt_pend     = pend;
      if (hard_rst) begin
         nxt          = PM_FULL;
         nxt_from_nap = 1'b0;
         nxt_pend     = 1'b0;
      end else begin
         unique case (state)
            PM_FULL: begin
               nxt_from_nap = 1'b0;
               nxt_pend     = 1'b0;
               if (psave_en && (req != PM_FULL) && !req_blocked) nxt = req;
            end
            PM_DOZE: begin
               if (wake_lp) begin
                  nxt          = PM_FULL;
                  nxt_from_nap = 1'b0;
               end else if (from_nap && qack) begin
                  nxt = PM_NAP;
               end
            end
            PM_NAP: begin
               if (wake_lp) begin
                  nxt          = PM_FULL;
                  nxt_from_nap = 1'b0;
               end else if (!qack) begin
                  nxt          = PM_DOZE;
                  nxt_from_nap = 1'b1;
               end
            end
            PM_SLEEP: begin
               nxt_pend = pend | wake_sl;
               if (lock_ok && nxt_pend) begin
                  nxt      = PM_FULL;
                  nxt_pend = 1'b0;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PM_FULL;
         from_nap  <= 1'b0;
         pend      <= 1'b0;
         wake_done <= 1'b0;
      end else begin
         state     <= nxt;
         from_nap  <= nxt_from_nap;
         pend      <= nxt_pend;
         wake_done <= (state != PM_FULL) && (nxt == PM_FULL);
      end
   end

   assign mode = state;

endmodule

// File: rtl/pmc_domain_gate.sv
module pmc_domain_gate
   import pmc_pkg::*;
#(
   parameter int NUM_UNITS   = 8,
   parameter bit DPM_SUPPORT = 1'b1
) (
   input  pm_mode_e             mode,
   input  logic                 dpm_en,
   input  logic [NUM_UNITS-1:0] unit_idle,
   output logic [NUM_UNITS-1:0] unit_en,
   output logic                 snoop_en,
   output logic                 timer_en,
   output logic                 thermal_en,
   output logic                 pll_en,
   output logic                 dll_en
);

   dom_en_t dom;

   assign dom        = mode_domains(mode);
   assign snoop_en   = dom.snoop;
   assign timer_en   = dom.timer;
   assign thermal_en = dom.thermal;
   assign pll_en     = dom.pll;
   assign dll_en     = dom.dll;

   generate
      if (DPM_SUPPORT) begin : g_dpm
         for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
            assign unit_en[i] = dom.units & ~(dpm_en & unit_idle[i]);
         end
      end else begin : g_no_dpm
         logic unused_dpm;
         assign unused_dpm = dpm_en ^ (^unit_idle);
         assign unit_en    = {NUM_UNITS{dom.units}};
      end
   endgenerate

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int NUM_UNITS   = 8,
   parameter int CNT_W       = 8,
   parameter bit DPM_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 psave_en,
   input  logic [1:0]           mode_sel,
   input  logic                 dpm_en,
   input  logic [NUM_UNITS-1:0] unit_idle,
   input  logic                 ext_irq,
   input  logic                 smi,
   input  logic                 dec_exc,
   input  logic                 soft_rst,
   input  logic                 hard_rst,
   input  logic                 mchk,
   input  logic                 qack,
   input  logic                 pll_locked,
   input  logic [CNT_W-1:0]     relock_cycles,
   output logic [NUM_UNITS-1:0] unit_en,
   output logic                 snoop_en,
   output logic                 timer_en,
   output logic                 thermal_en,
   output logic                 pll_en,
   output logic                 dll_en,
   output logic [1:0]           cur_mode,
   output logic                 wake_done
);

   generate
      if (NUM_UNITS < 1) begin : g_bad_units
         $error("pwr_mode_ctrl: NUM_UNITS must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
         $error("pwr_mode_ctrl: CNT_W must lie in 1..31");
      end
   endgenerate

   pm_mode_e mode;
   logic     lock_ok;

   pmc_relock_timer #(.CNT_W(CNT_W)) u_relock (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_sleep      (mode == PM_SLEEP),
      .pll_locked    (pll_locked),
      .relock_cycles (relock_cycles),
      .lock_ok       (lock_ok)
   );

   pmc_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .psave_en  (psave_en),
      .mode_sel  (mode_sel),
      .ext_irq   (ext_irq),
      .smi       (smi),
      .dec_exc   (dec_exc),
      .soft_rst  (soft_rst),
      .hard_rst  (hard_rst),
      .mchk      (mchk),
      .qack      (qack),
      .lock_ok   (lock_ok),
      .mode      (mode),
      .wake_done (wake_done)
   );

   pmc_domain_gate #(.NUM_UNITS(NUM_UNITS), .DPM_SUPPORT(DPM_SUPPORT)) u_gate (
      .mode       (mode),
      .dpm_en     (dpm_en),
      .unit_idle  (unit_idle),
      .unit_en    (unit_en),
      .snoop_en   (snoop_en),
      .timer_en   (timer_en),
      .thermal_en (thermal_en),
      .pll_en     (pll_en),
      .dll_en     (dll_en)
   );

   assign cur_mode = mode;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int NUM_UNITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ext_irq,
   input logic                 smi,
   input logic                 dec_exc,
   input logic                 soft_rst,
   input logic                 hard_rst,
   input logic                 mchk,
   input logic                 qack,
   input logic                 pll_locked,
   input logic [NUM_UNITS-1:0] unit_en,
   input logic                 snoop_en,
   input logic                 timer_en,
   input logic                 pll_en,
   input logic [1:0]           cur_mode,
   input logic                 wake_done
);

   logic wake_any;
   assign wake_any = ext_irq | smi | dec_exc | soft_rst | mchk;

   a_r10_hard_rst_full: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst |=> cur_mode == 2'b00);

   a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |=> !wake_done);

   a_r11_pulse_on_return: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |-> (cur_mode == 2'b00) && ($past(cur_mode) != 2'b00));

   a_r5_lp_wake: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_mode == 2'b01) || (cur_mode == 2'b10)) && wake_any |=> cur_mode == 2'b00);

   a_r6_nap_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b10) && !qack && !wake_any && !hard_rst |=> cur_mode == 2'b01);

   a_r9_sleep_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b11) && !pll_locked && !hard_rst |=> cur_mode == 2'b11);

   a_r4_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b11) |-> (unit_en == '0) && !snoop_en && !timer_en && !pll_en);

   a_r4_nap_snoop_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b10) |-> !snoop_en && timer_en && pll_en && (unit_en == '0));

endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_irq    (ext_irq),
   .smi        (smi),
   .dec_exc    (dec_exc),
   .soft_rst   (soft_rst),
   .hard_rst   (hard_rst),
   .mchk       (mchk),
   .qack       (qack),
   .pll_locked (pll_locked),
   .unit_en    (unit_en),
   .snoop_en   (snoop_en),
   .timer_en   (timer_en),
   .pll_en     (pll_en),
   .cur_mode   (cur_mode),
   .wake_done  (wake_done)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NU         = 4;
   localparam int CW         = 4;
   localparam int N_RANDOM   = 4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psave_en = 0, dpm_en = 0;
   logic [1:0]    mode_sel = 0;
   logic [NU-1:0] unit_idle = 0;
   logic          ext_irq = 0, smi = 0, dec_exc = 0, soft_rst = 0, hard_rst = 0, mchk = 0;
   logic          qack = 1, pll_locked = 0;
   logic [CW-1:0] relock_cycles = 4'd2;
   logic [NU-1:0] unit_en;
   logic          snoop_en, timer_en, thermal_en, pll_en, dll_en, wake_done;
   logic [1:0]    cur_mode;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  rnd_on = 0;
   bit  done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.NUM_UNITS(NU), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .psave_en(psave_en), .mode_sel(mode_sel),
      .dpm_en(dpm_en), .unit_idle(unit_idle), .ext_irq(ext_irq), .smi(smi),
      .dec_exc(dec_exc), .soft_rst(soft_rst), .hard_rst(hard_rst), .mchk(mchk),
      .qack(qack), .pll_locked(pll_locked), .relock_cycles(relock_cycles),
      .unit_en(unit_en), .snoop_en(snoop_en), .timer_en(timer_en),
      .thermal_en(thermal_en), .pll_en(pll_en), .dll_en(dll_en),
      .cur_mode(cur_mode), .wake_done(wake_done)
   );

   // ---------------- reference model ----------------
   logic [1:0]    m_mode;
   logic          m_fn, m_pd, m_wd;
   logic [CW-1:0] m_cnt;
   string         m_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      logic [1:0] nm;
      logic       fn, pd, wsl, wlp, lok;
      string      tg;
      if (!rst_n) begin
         m_mode <= 2'b00; m_fn <= 0; m_pd <= 0; m_wd <= 0; m_cnt <= '0; m_tag <= "R1";
      end else begin
         wsl = ext_irq | smi | soft_rst | mchk;
         wlp = wsl | dec_exc;
         lok = pll_locked && (m_cnt >= relock_cycles);
         nm = m_mode; fn = m_fn; pd = m_pd; tg = "R2";
         if (hard_rst) begin
            nm = 2'b00; fn = 0; pd = 0; tg = "R10";
         end else begin
            case (m_mode)
               2'b00: begin
                  fn = 0; pd = 0;
                  if (psave_en && mode_sel != 2'b00 && !((mode_sel == 2'b11) ? wsl : wlp))
                     nm = mode_sel;
               end
               2'b01: begin
                  tg = "R7";
                  if (wlp) begin nm = 2'b00; fn = 0; tg = "R5"; end
                  else if (m_fn && qack) nm = 2'b10;
               end
               2'b10: begin
                  tg = "R6";
                  if (wlp) begin nm = 2'b00; fn = 0; tg = "R5"; end
                  else if (!qack) begin nm = 2'b01; fn = 1; end
               end
               default: begin
                  tg = dec_exc ? "R8" : "R9";
                  pd = m_pd | wsl;
                  if (lok && pd) begin nm = 2'b00; pd = 0; end
               end
            endcase
         end
         m_wd   <= (m_mode != 2'b00) && (nm == 2'b00);
         m_mode <= nm; m_fn <= fn; m_pd <= pd; m_tag <= tg;
         if (m_mode != 2'b11 || !pll_locked) m_cnt <= '0;
         else if (m_cnt != '1) m_cnt <= m_cnt + 1'b1;
      end
   end

   // Expected enables {units, snoop, timer, thermal, pll, dll}
   function automatic logic [NU+4:0] exp_en(logic [1:0] md, logic dpm, logic [NU-1:0] idle);
      logic [NU-1:0] u;
      logic [4:0]    d;
      u = (md == 2'b00) ? ~({NU{dpm}} & idle) : '0;
      case (md)
         2'b00:   d = 5'b11111;
         2'b01:   d = 5'b11111;
         2'b10:   d = 5'b01111;
         default: d = 5'b00000;
      endcase
      return {u, d};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk_en(string tag);
      chk(tag, "enables", 32'({unit_en, snoop_en, timer_en, thermal_en, pll_en, dll_en}),
          32'(exp_en(cur_mode, dpm_en, unit_idle)));
   endtask

   always @(negedge clk) begin
      if (rnd_on && rst_n) begin
         #1;
         chk(m_tag, "cur_mode", 32'(cur_mode), 32'(m_mode));
         chk("R11", "wake_done", 32'(wake_done), 32'(m_wd));
         chk_en((m_mode == 2'b00) ? "R3" : "R4");
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "cur_mode", 32'(cur_mode), 0);
      chk("R1", "wake_done", 32'(wake_done), 0);
      chk("R1", "enables", 32'({unit_en, snoop_en, timer_en, thermal_en, pll_en, dll_en}), 32'h1FF);
      // R3 dynamic idle gating
      @(negedge clk); dpm_en = 1; unit_idle = 4'b0101; #1;
      chk("R3", "unit_en", 32'(unit_en), 32'hA);
      chk("R3", "snoop_en", 32'(snoop_en), 1);
      // R2 mode_sel 00 ignored
      psave_en = 1; mode_sel = 2'b00; tick();
      chk("R2", "cur_mode sel00", 32'(cur_mode), 0);
      // R2 request refused with wake present
      mode_sel = 2'b01; ext_irq = 1; tick();
      chk("R2", "cur_mode blocked", 32'(cur_mode), 0);
      ext_irq = 0; tick();
      chk("R2", "cur_mode doze", 32'(cur_mode), 1);
      psave_en = 0; #1;
      chk("R4", "doze unit_en", 32'(unit_en), 0);
      chk("R4", "doze snoop_en", 32'(snoop_en), 1);
      // R7 doze from full ignores qack
      qack = 0; tick(); qack = 1; tick();
      chk("R7", "doze stays", 32'(cur_mode), 1);
      // R5 decrementer wakes doze
      dec_exc = 1; tick(); dec_exc = 0;
      chk("R5", "wake to full", 32'(cur_mode), 0);
      chk("R11", "wake_done high", 32'(wake_done), 1);
      tick();
      chk("R11", "wake_done low", 32'(wake_done), 0);
      // nap, fallback and return
      psave_en = 1; mode_sel = 2'b10; tick(); psave_en = 0;
      chk("R2", "cur_mode nap", 32'(cur_mode), 2);
      chk("R4", "nap snoop_en", 32'(snoop_en), 0);
      chk("R4", "nap pll_en", 32'(pll_en), 1);
      qack = 0; tick();
      chk("R6", "nap to doze", 32'(cur_mode), 1);
      qack = 1; tick();
      chk("R7", "doze back to nap", 32'(cur_mode), 2);
      // R5 wake and qack fall in the same edge: wake wins
      qack = 0; smi = 1; tick(); smi = 0; qack = 1;
      chk("R5", "wake beats fallback", 32'(cur_mode), 0);
      // sleep
      pll_locked = 0; psave_en = 1; mode_sel = 2'b11; tick(); psave_en = 0;
      chk("R4", "sleep pll_en", 32'(pll_en), 0);
      dec_exc = 1; tick(); dec_exc = 0;
      chk("R8", "dec ignored in sleep", 32'(cur_mode), 3);
      ext_irq = 1; tick(); ext_irq = 0;
      chk("R9", "held while unlocked", 32'(cur_mode), 3);
      pll_locked = 1; tick();
      chk("R9", "lock edge 1", 32'(cur_mode), 3);
      tick();
      chk("R9", "lock edge 2", 32'(cur_mode), 3);
      tick();
      chk("R9", "lock satisfied", 32'(cur_mode), 0);
      chk("R11", "sleep exit pulse", 32'(wake_done), 1);
      // R10 hard reset with qack fall in nap
      psave_en = 1; mode_sel = 2'b10; tick(); psave_en = 0;
      qack = 0; hard_rst = 1; tick(); hard_rst = 0; qack = 1;
      chk("R10", "hard reset wins", 32'(cur_mode), 0);
      chk("R11", "hard reset pulse", 32'(wake_done), 1);
      tick();

      // random phase against model
      void'($urandom(32'd1234));
      rnd_on = 1;
      for (int i = 0; i < N_RANDOM; i++) begin
         @(negedge clk);
         psave_en  = ($urandom % 4) == 0;
         mode_sel  = 2'($urandom);
         dpm_en    = 1'($urandom);
         unit_idle = NU'($urandom);
         ext_irq   = ($urandom % 24) == 0;
         smi       = ($urandom % 24) == 0;
         dec_exc   = ($urandom % 12) == 0;
         soft_rst  = ($urandom % 40) == 0;
         mchk      = ($urandom % 40) == 0;
         hard_rst  = ($urandom % 90) == 0;
         if (($urandom % 5) == 0) qack = ~qack;
         if (($urandom % 7) == 0) pll_locked = ~pll_locked;
         if (($urandom % 64) == 0) relock_cycles = CW'($urandom % 8);
      end
      @(negedge clk);
      rnd_on = 0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule